// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache with Preload Hint

This block sits between a processor load/store port and a plain word-wide memory port. It holds recently used lines in a set-associative store of four ways. Reads and writes that find their line resident finish without touching memory. Writes update only the cached copy and set the line's dirty flag. A miss allocates a line, whether the request is a read or a write. If the chosen victim is dirty, the old line is copied back to memory before the new line is brought in.

A preload strobe names an address whose line should be brought in ahead of use. It returns no data to the requester. Addresses with the top address bit set are treated as uncached and go straight to memory as a single word. When the enable input is low, the same direct path is used for every request.

All valid and dirty flags are cleared at reset, so the first touch of any address misses. A bulk-invalidate pulse clears them again at any idle moment, and it discards dirty contents without copying them back. When a set has no free way, the victim is drawn from a free-running pseudo-random sequence.

Top module: `wb_dcache`

## Requirements
- R1: After reset the cache is idle (`cpu_busy`=0, `cpu_done`=0, `mem_req`=0) and holds no valid line, so the first access to any cacheable address reports `cpu_hit`=0.
- R2: A read miss fetches exactly the four words of the containing line (four read beats, no write beats) and returns the addressed word. Later reads of any word of that line report `cpu_hit`=1 with no memory traffic.
- R3: A write that hits stores `cpu_wdata` in the cache only: there is no memory traffic, a later read returns the new value, and memory keeps its old value.
- R4: A write that misses first fills the line from memory (four read beats) and then merges the written word. The other words of the line keep their memory values.
- R5: When the victim line is dirty, its four words are written to memory before any read beat of the new line is issued. Memory then holds the written data of exactly that line.
- R6: While a set still has an invalid way, a miss fills an invalid way. Four distinct lines mapping to one set therefore all stay resident.
- R7: In a set whose four ways are all valid, the victim way is taken from the two low bits of a free-running 16-bit LFSR. A fifth line mapping to a full set displaces one of the four earlier lines.
- R8: A preload (`cpu_pld`=1) that misses fetches the line with four read beats and completes with `cpu_hit`=0 and `cpu_rdata`=0. A preload that hits, or one to an uncached address, completes with no memory traffic.
- R9: Linefills start only on a demand miss or a preload. A miss fetches no other line, so the following line still misses afterwards.
- R10: An address with bit 31 set is uncached. Each read or write to it is one memory beat to the same address, reports `cpu_hit`=0, and never allocates a line.
- R11: With `enable`=0 every request is a single direct memory beat. Cache contents are neither read nor changed, so a dirty line is still resident with its data once enable returns to 1.
- R12: A one-cycle `inval_all` pulse while idle clears every valid and dirty flag without writing anything back. The next access to a previously resident line misses and returns the memory value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = caching on; 0 = every request goes direct to memory |
| inval_all | input | 1 | Pulse while idle to clear all valid and dirty flags |
| cpu_valid | input | 1 | One-cycle request strobe, accepted when `cpu_busy` is 0 |
| cpu_we | input | 1 | 1 = write request, 0 = read request |
| cpu_pld | input | 1 | 1 = preload hint (overrides `cpu_we`) |
| cpu_addr | input | 32 | Byte address of the request (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | A request is in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | With `cpu_done`: line was resident with no memory traffic |
| cpu_rdata | output | 32 | With `cpu_done`: read data (0 for preload) |
| mem_req | output | 1 | Memory beat request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_ack | input | 1 | Beat accepted or completed |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ack` |

## Verification
The main function is exercised with cold reads, write hits and write misses, and four lines sharing one set. Each case is told apart by its count of read and write beats and by the returned data. Two fill patterns into a set separate victim choices. Clean lines in the set expose whether invalid ways are preferred. All-dirty lines force a writeback whose beat order and final memory image show write-before-fill and the identity of the evicted line. Preload, uncached, disabled and invalidate patterns are each recognised by their traffic count against the cache contents read back afterwards.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_EVICT,
      ST_FILL,
      ST_DIRECT
   } dc_state_e;
endpackage

// File: rtl/dc_lfsr.sv
module dc_lfsr #(
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [15:0] q
);
   generate
      if (SEED == 16'h0) begin : g_bad_seed
         $error("dc_lfsr: seed must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= SEED;
      else        q <= {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
   end
endmodule

// File: rtl/dc_victim.sv
module dc_victim #(
   parameter int WAYS  = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  val_vec,
   input  logic [WAY_W-1:0] rnd,
   output logic [WAY_W-1:0] way
);
   logic             free_any;
   logic [WAY_W-1:0] free_way;

   always_comb begin
      free_any = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!val_vec[w]) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   assign way = free_any ? free_way : rnd;
endmodule

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int WAYS  = 4,
   parameter int SETS  = 64,
   parameter int TAG_W = 22,
   localparam int WAY_W = $clog2(WAYS),
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear_all,
   input  logic [IDX_W-1:0]            lk_idx,
   input  logic [TAG_W-1:0]            lk_tag,
   output logic [WAYS-1:0]             hit_vec,
   output logic [WAYS-1:0]             val_vec,
   output logic [WAYS-1:0]             dty_vec,
   output logic [WAYS-1:0][TAG_W-1:0]  tags_o,
   input  logic                        alloc_en,
   input  logic [WAY_W-1:0]            alloc_way,
   input  logic [TAG_W-1:0]            alloc_tag,
   input  logic                        mark_en,
   input  logic [WAY_W-1:0]            mark_way
);
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic [SETS-1:0]  v_q;
         logic [SETS-1:0]  d_q;
         logic [TAG_W-1:0] t_q [SETS];
         logic             sel_alloc;
         logic             sel_mark;

         assign sel_alloc = alloc_en && (alloc_way == WAY_W'(w));
         assign sel_mark  = mark_en && (mark_way == WAY_W'(w));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= '0;
               d_q <= '0;
            end else if (clear_all) begin
               v_q <= '0;
               d_q <= '0;
            end else if (sel_alloc) begin
               v_q[lk_idx] <= 1'b1;
               d_q[lk_idx] <= 1'b0;
            end else if (sel_mark) begin
               d_q[lk_idx] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (sel_alloc) t_q[lk_idx] <= alloc_tag;
         end

         assign val_vec[w] = v_q[lk_idx];
         assign dty_vec[w] = d_q[lk_idx];
         assign tags_o[w]  = t_q[lk_idx];
         assign hit_vec[w] = v_q[lk_idx] && (t_q[lk_idx] == lk_tag);
      end
   endgenerate
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
   parameter int WAYS       = 4,
   parameter int SETS       = 64,
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 32,
   localparam int WAY_W = $clog2(WAYS),
   localparam int IDX_W = $clog2(SETS),
   localparam int WRD_W = $clog2(LINE_WORDS),
   localparam int DEPTH = WAYS * SETS * LINE_WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WAY_W-1:0]  rd_way,
   input  logic [WRD_W-1:0]  rd_word,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [WRD_W-1:0]  wr_word,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[{wr_way, idx, wr_word}] <= wr_data;
   end

   assign rd_data = mem_q[{rd_way, idx, rd_word}];
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
   import dc_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          DATA_W     = 32,
   parameter int          WAYS       = 4,
   parameter int          SETS       = 64,
   parameter int          LINE_WORDS = 4,
   parameter int          NC_BIT     = 31,
   parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              inval_all,
   input  logic              cpu_valid,
   input  logic              cpu_we,
   input  logic              cpu_pld,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int WRD_W  = $clog2(LINE_WORDS);
   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int TAG_W  = ADDR_W - IDX_W - WRD_W - BYTE_W;
   localparam logic [WRD_W-1:0] LAST_BEAT = WRD_W'(LINE_WORDS - 1);

   generate
      if (WAYS < 2 || WAYS > 16 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("wb_dcache: WAYS must be a power of two from 2 to 16");
      end
      if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
         $error("wb_dcache: SETS must be a power of two");
      end
      if (LINE_WORDS < 2 || (1 << WRD_W) != LINE_WORDS) begin : g_bad_line
         $error("wb_dcache: LINE_WORDS must be a power of two of at least 2");
      end
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("wb_dcache: DATA_W must be whole bytes, at least 16 bits");
      end
      if (TAG_W < 1 || NC_BIT >= ADDR_W || NC_BIT < ADDR_W - TAG_W) begin : g_bad_tag
         $error("wb_dcache: address split or uncached bit out of range");
      end
   endgenerate

   dc_state_e          st_q;
   logic [ADDR_W-1:0]  a_q;
   logic [DATA_W-1:0]  wd_q;
   logic               we_q;
   logic               pld_q;
   logic               refill_q;
   logic [WAY_W-1:0]   way_q;
   logic [WRD_W-1:0]   beat_q;
   logic [TAG_W-1:0]   vtag_q;
   logic               done_q;
   logic               hit_q;
   logic [DATA_W-1:0]  rdata_q;

   logic [IDX_W-1:0]   a_idx;
   logic [TAG_W-1:0]   a_tag;
   logic [WRD_W-1:0]   a_wrd;
   logic               bypass;
   logic [WAYS-1:0]    hit_vec;
   logic [WAYS-1:0]    val_vec;
   logic [WAYS-1:0]    dty_vec;
   logic [WAYS-1:0][TAG_W-1:0] tags_v;
   logic               any_hit;
   logic [WAY_W-1:0]   hit_way;
   logic [WAY_W-1:0]   vict_way;
   logic [15:0]        lfsr_q;
   logic               miss_go;
   logic               look_hit;
   logic               wr_hit;
   logic               ts_clear;
   logic               alloc_en;
   logic               st_wr_en;
   logic [WAY_W-1:0]   st_rd_way;
   logic [WRD_W-1:0]   st_rd_word;
   logic [WAY_W-1:0]   st_wr_way;
   logic [WRD_W-1:0]   st_wr_word;
   logic [DATA_W-1:0]  st_wr_data;
   logic [DATA_W-1:0]  st_rd_data;

   assign a_idx  = a_q[BYTE_W + WRD_W +: IDX_W];
   assign a_tag  = a_q[ADDR_W-1 -: TAG_W];
   assign a_wrd  = a_q[BYTE_W +: WRD_W];
   assign bypass = a_q[NC_BIT] || !enable;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   assign any_hit  = |hit_vec;
   assign look_hit = (st_q == ST_LOOK) && !bypass && any_hit;
   assign miss_go  = (st_q == ST_LOOK) && !bypass && !any_hit;
   assign wr_hit   = look_hit && we_q && !pld_q;
   assign ts_clear = inval_all && (st_q == ST_IDLE);
   assign alloc_en = (st_q == ST_FILL) && mem_ack && (beat_q == LAST_BEAT);

   dc_lfsr #(.SEED(LFSR_SEED)) i_lfsr (
      .clk (clk),
      .rst_n (rst_n),
      .q (lfsr_q)
   );

   dc_victim #(.WAYS(WAYS)) i_victim (
      .val_vec (val_vec),
      .rnd (lfsr_q[WAY_W-1:0]),
      .way (vict_way)
   );

   dc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) i_tags (
      .clk (clk),
      .rst_n (rst_n),
      .clear_all (ts_clear),
      .lk_idx (a_idx),
      .lk_tag (a_tag),
      .hit_vec (hit_vec),
      .val_vec (val_vec),
      .dty_vec (dty_vec),
      .tags_o (tags_v),
      .alloc_en (alloc_en),
      .alloc_way (way_q),
      .alloc_tag (a_tag),
      .mark_en (wr_hit),
      .mark_way (hit_way)
   );

   assign st_rd_way  = (st_q == ST_EVICT) ? way_q  : hit_way;
   assign st_rd_word = (st_q == ST_EVICT) ? beat_q : a_wrd;
   assign st_wr_en   = wr_hit || ((st_q == ST_FILL) && mem_ack);
   assign st_wr_way  = (st_q == ST_FILL) ? way_q     : hit_way;
   assign st_wr_word = (st_q == ST_FILL) ? beat_q    : a_wrd;
   assign st_wr_data = (st_q == ST_FILL) ? mem_rdata : wd_q;

   dc_data_store #(
      .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
   ) i_data (
      .clk (clk),
      .idx (a_idx),
      .rd_way (st_rd_way),
      .rd_word (st_rd_word),
      .rd_data (st_rd_data),
      .wr_en (st_wr_en),
      .wr_way (st_wr_way),
      .wr_word (st_wr_word),
      .wr_data (st_wr_data)
   );

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = a_q;
      mem_wdata = wd_q;
      unique case (st_q)
         ST_EVICT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {vtag_q, a_idx, beat_q, {BYTE_W{1'b0}}};
            mem_wdata = st_rd_data;
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {a_tag, a_idx, beat_q, {BYTE_W{1'b0}}};
         end
         ST_DIRECT: begin
            mem_req = 1'b1;
            mem_we  = we_q && !pld_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         a_q      <= '0;
         wd_q     <= '0;
         we_q     <= 1'b0;
         pld_q    <= 1'b0;
         refill_q <= 1'b0;
         way_q    <= '0;
         beat_q   <= '0;
         vtag_q   <= '0;
         done_q   <= 1'b0;
         hit_q    <= 1'b0;
         rdata_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (!inval_all && cpu_valid) begin
                  a_q      <= cpu_addr;
                  wd_q     <= cpu_wdata;
                  we_q     <= cpu_we;
                  pld_q    <= cpu_pld;
                  refill_q <= 1'b0;
                  st_q     <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (bypass) begin
                  if (pld_q) begin
                     done_q  <= 1'b1;
                     hit_q   <= 1'b0;
                     rdata_q <= '0;
                     st_q    <= ST_IDLE;
                  end else begin
                     st_q <= ST_DIRECT;
                  end
               end else if (any_hit) begin
                  done_q  <= 1'b1;
                  hit_q   <= !refill_q;
                  rdata_q <= pld_q ? '0 : st_rd_data;
                  st_q    <= ST_IDLE;
               end else begin
                  way_q    <= vict_way;
                  vtag_q   <= tags_v[vict_way];
                  beat_q   <= '0;
                  refill_q <= 1'b1;
                  st_q     <= (val_vec[vict_way] && dty_vec[vict_way]) ? ST_EVICT : ST_FILL;
               end
            end
            ST_EVICT: begin
               if (mem_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST_BEAT) st_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST_BEAT) st_q <= ST_LOOK;
               end
            end
            ST_DIRECT: begin
               if (mem_ack) begin
                  done_q  <= 1'b1;
                  hit_q   <= 1'b0;
                  rdata_q <= we_q ? '0 : mem_rdata;
                  st_q    <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_busy  = (st_q != ST_IDLE);
   assign cpu_done  = done_q;
   assign cpu_hit   = hit_q;
   assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dc_chk.sv
module dc_chk
   import dc_pkg::*;
#(
   parameter int WAYS       = 4,
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 4,
   localparam int WAY_W = $clog2(WAYS),
   localparam int CNT_W = $clog2(LINE_WORDS) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input dc_state_e         st,
   input logic              cpu_busy,
   input logic              cpu_done,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              miss_go,
   input logic [WAYS-1:0]   val_vec,
   input logic [WAY_W-1:0]  vict_way,
   input logic [15:0]       lfsr
);
   logic [CNT_W-1:0] wb_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        wb_cnt <= '0;
      else if (st == ST_LOOK)            wb_cnt <= '0;
      else if (st == ST_EVICT && mem_ack) wb_cnt <= wb_cnt + 1'b1;
   end

   // R1: no memory beat while idle
   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |-> !mem_req);

   // R1: completion is reported with the block idle
   p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_busy);

   // R2: a pending beat keeps its request, address and direction
   p_beat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R5: read beats of a fill never interleave with an unfinished writeback
   p_wb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL && mem_req) |-> (wb_cnt == '0 || wb_cnt == CNT_W'(LINE_WORDS)));

   // R6: a free way is always chosen over a valid one
   p_free_way_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_go && !(&val_vec)) |-> !val_vec[vict_way]);

   // R7: the random source never locks up
   p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lfsr != 16'h0) |=> (lfsr != $past(lfsr)));

   // R10: a direct access is exactly one beat
   p_one_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DIRECT && mem_ack) |=> !mem_req);
endmodule

bind wb_dcache dc_chk #(
   .WAYS(WAYS), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)
) i_dc_chk (
   .clk (clk),
   .rst_n (rst_n),
   .st (st_q),
   .cpu_busy (cpu_busy),
   .cpu_done (cpu_done),
   .mem_req (mem_req),
   .mem_we (mem_we),
   .mem_ack (mem_ack),
   .mem_addr (mem_addr),
   .miss_go (miss_go),
   .val_vec (val_vec),
   .vict_way (vict_way),
   .lfsr (lfsr_q)
);

// File: tb/test_wb_dcache.sv
module test_wb_dcache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b1;
   logic        inval_all = 1'b0;
   logic        cpu_valid = 1'b0;
   logic        cpu_we = 1'b0;
   logic        cpu_pld = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_busy, cpu_done, cpu_hit;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   wb_dcache i_wb_dcache (
      .clk (clk), .rst_n (rst_n), .enable (enable), .inval_all (inval_all),
      .cpu_valid (cpu_valid), .cpu_we (cpu_we), .cpu_pld (cpu_pld),
      .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
      .cpu_busy (cpu_busy), .cpu_done (cpu_done), .cpu_hit (cpu_hit),
      .cpu_rdata (cpu_rdata),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
   );

   // memory model: one beat per two cycles, contents default to a hash
   logic [31:0] mem [0:16383];
   logic        wrt [0:16383];
   logic        kinds [0:1023];
   int          nbeat = 0;
   int          nrd = 0;
   int          nwr = 0;

   function automatic logic [31:0] gold(input int i);
      return (i * 32'h9E3779B1) + 32'h0000_0007;
   endfunction

   function automatic logic [31:0] exp_mem(input logic [31:0] a);
      int i;
      i = int'(a[15:2]);
      return (wrt[i] === 1'b1) ? mem[i] : gold(i);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr[15:2]] <= mem_wdata;
            wrt[mem_addr[15:2]] <= 1'b1;
            nwr <= nwr + 1;
         end else begin
            mem_rdata <= exp_mem(mem_addr);
            nrd <= nrd + 1;
         end
         if (nbeat < 1024) kinds[nbeat] <= mem_we;
         nbeat <= nbeat + 1;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic go(input bit pld, input bit we, input logic [31:0] a,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output bit hit, output int rb, output int wb, output int b0);
      int r0, w0;
      @(negedge clk);
      while (cpu_busy) @(negedge clk);
      b0 = nbeat; r0 = nrd; w0 = nwr;
      cpu_valid = 1'b1; cpu_pld = pld; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      @(negedge clk);
      cpu_valid = 1'b0; cpu_pld = 1'b0; cpu_we = 1'b0;
      while (!cpu_done) @(negedge clk);
      rd = cpu_rdata; hit = cpu_hit; rb = nrd - r0; wb = nwr - w0;
   endtask

   logic [31:0] rd;
   bit hit;
   int rb, wb, b0;

   task automatic t_reset();
      @(negedge clk);
      chk(cpu_busy == 1'b0, "R1", "busy after reset", 32'(cpu_busy), 0);
      chk(cpu_done == 1'b0, "R1", "done after reset", 32'(cpu_done), 0);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);
   endtask

   task automatic t_cold();
      go(0, 0, 32'h100, 0, rd, hit, rb, wb, b0);
      chk(!hit, "R1", "first access hit", 32'(hit), 0);
      chk(rd == exp_mem(32'h100), "R2", "miss data", rd, exp_mem(32'h100));
      chk(rb == 4 && wb == 0, "R2", "fill beats", 32'(rb * 16 + wb), 32'h40);
      go(0, 0, 32'h10C, 0, rd, hit, rb, wb, b0);
      chk(hit && rb == 0, "R2", "same line hit", 32'(hit), 1);
      chk(rd == exp_mem(32'h10C), "R2", "hit data", rd, exp_mem(32'h10C));
      go(0, 0, 32'h110, 0, rd, hit, rb, wb, b0);
      chk(!hit && rb == 4, "R9", "next line not prefetched", 32'(hit), 0);
   endtask

   task automatic t_write_hit();
      go(0, 1, 32'h104, 32'hA5A5_0104, rd, hit, rb, wb, b0);
      chk(hit && rb == 0 && wb == 0, "R3", "write hit traffic", 32'(rb + wb), 0);
      go(0, 0, 32'h104, 0, rd, hit, rb, wb, b0);
      chk(rd == 32'hA5A5_0104, "R3", "write hit readback", rd, 32'hA5A5_0104);
      chk(exp_mem(32'h104) == gold(32'h104 >> 2), "R3", "memory untouched",
          exp_mem(32'h104), gold(32'h104 >> 2));
   endtask

   task automatic t_write_miss();
      go(0, 1, 32'h208, 32'hB0B0_0208, rd, hit, rb, wb, b0);
      chk(!hit && rb == 4 && wb == 0, "R4", "write miss fill", 32'(rb), 4);
      go(0, 0, 32'h208, 0, rd, hit, rb, wb, b0);
      chk(hit && rd == 32'hB0B0_0208, "R4", "merged word", rd, 32'hB0B0_0208);
      go(0, 0, 32'h20C, 0, rd, hit, rb, wb, b0);
      chk(hit && rd == gold(32'h20C >> 2), "R4", "neighbour word", rd, gold(32'h20C >> 2));
   endtask

   task automatic t_ways();
      int misses;
      for (int k = 1; k < 4; k++) begin
         go(0, 0, 32'h100 + k * 32'h400, 0, rd, hit, rb, wb, b0);
         chk(rb == 4 && wb == 0, "R6", "fill into free way", 32'(rb * 16 + wb), 32'h40);
      end
      misses = 0;
      for (int k = 0; k < 4; k++) begin
         go(0, 0, 32'h104 + k * 32'h400, 0, rd, hit, rb, wb, b0);
         if (!hit) misses++;
      end
      chk(misses == 0, "R6", "four lines resident", 32'(misses), 0);
      // fifth line into the full set
      go(0, 0, 32'h1100, 0, rd, hit, rb, wb, b0);
      chk(rb == 4 && (wb == 0 || wb == 4), "R7", "fifth line beats", 32'(rb * 16 + wb), 32'h40);
      misses = 0;
      for (int k = 0; k < 4; k++) begin
         go(0, 0, 32'h104 + k * 32'h400, 0, rd, hit, rb, wb, b0);
         if (!hit) misses++;
         if (k == 0) chk(rd == 32'hA5A5_0104, "R5", "dirty data survives", rd, 32'hA5A5_0104);
      end
      chk(misses >= 1, "R7", "one earlier line displaced", 32'(misses), 1);
   endtask

   task automatic t_dirty();
      int seen, order_ok;
      for (int k = 0; k < 4; k++)
         go(0, 1, 32'h300 + k * 32'h400, 32'hD000_0000 + k, rd, hit, rb, wb, b0);
      go(0, 0, 32'h1300, 0, rd, hit, rb, wb, b0);
      chk(wb == 4 && rb == 4, "R5", "dirty eviction beats", 32'(wb * 16 + rb), 32'h44);
      order_ok = 1;
      for (int k = 0; k < 8; k++)
         if (kinds[b0 + k] !== (k < 4)) order_ok = 0;
      chk(order_ok == 1, "R5", "writeback before fill", 32'(order_ok), 1);
      seen = 0;
      for (int k = 0; k < 4; k++)
         if (exp_mem(32'h300 + k * 32'h400) == 32'hD000_0000 + k) seen++;
      chk(seen == 1, "R5", "one line written back", 32'(seen), 1);
      chk(rd == exp_mem(32'h1300), "R5", "new line data", rd, exp_mem(32'h1300));
   endtask

   task automatic t_preload();
      go(1, 0, 32'h2000, 0, rd, hit, rb, wb, b0);
      chk(!hit && rb == 4 && wb == 0 && rd == 0, "R8", "preload miss", 32'(rb), 4);
      go(0, 0, 32'h2008, 0, rd, hit, rb, wb, b0);
      chk(hit && rb == 0 && rd == exp_mem(32'h2008), "R8", "preloaded line hits", rd, exp_mem(32'h2008));
      go(1, 0, 32'h2004, 0, rd, hit, rb, wb, b0);
      chk(rb == 0 && wb == 0, "R8", "preload hit quiet", 32'(rb + wb), 0);
      go(1, 0, 32'h8000_2040, 0, rd, hit, rb, wb, b0);
      chk(rb == 0 && wb == 0, "R8", "uncached preload quiet", 32'(rb + wb), 0);
   endtask

   task automatic t_uncached();
      for (int k = 0; k < 2; k++) begin
         go(0, 0, 32'h8000_3000, 0, rd, hit, rb, wb, b0);
         chk(!hit && rb == 1 && rd == exp_mem(32'h3000), "R10", "uncached read", rd, exp_mem(32'h3000));
      end
      go(0, 1, 32'h8000_3004, 32'hCAFE_3004, rd, hit, rb, wb, b0);
      chk(wb == 1 && exp_mem(32'h3004) == 32'hCAFE_3004, "R10", "uncached write", exp_mem(32'h3004), 32'hCAFE_3004);
      go(0, 0, 32'h8000_3004, 0, rd, hit, rb, wb, b0);
      chk(rb == 1 && rd == 32'hCAFE_3004, "R10", "uncached readback", rd, 32'hCAFE_3004);
   endtask

   task automatic t_disabled();
      enable = 1'b0;
      go(0, 0, 32'h208, 0, rd, hit, rb, wb, b0);
      chk(rb == 1 && rd == gold(32'h208 >> 2), "R11", "disabled read direct", rd, gold(32'h208 >> 2));
      go(0, 1, 32'h20C, 32'hEEEE_020C, rd, hit, rb, wb, b0);
      chk(wb == 1 && exp_mem(32'h20C) == 32'hEEEE_020C, "R11", "disabled write direct", exp_mem(32'h20C), 32'hEEEE_020C);
      enable = 1'b1;
      go(0, 0, 32'h208, 0, rd, hit, rb, wb, b0);
      chk(hit && rd == 32'hB0B0_0208, "R11", "cached dirty kept", rd, 32'hB0B0_0208);
      go(0, 0, 32'h20C, 0, rd, hit, rb, wb, b0);
      chk(hit && rd == gold(32'h20C >> 2), "R11", "cached copy unchanged", rd, gold(32'h20C >> 2));
   endtask

   task automatic t_inval();
      @(negedge clk);
      while (cpu_busy) @(negedge clk);
      inval_all = 1'b1;
      @(negedge clk);
      inval_all = 1'b0;
      go(0, 0, 32'h208, 0, rd, hit, rb, wb, b0);
      chk(!hit && rb == 4 && wb == 0, "R12", "miss after invalidate", 32'(rb * 16 + wb), 32'h40);
      chk(rd == gold(32'h208 >> 2), "R12", "dirty data dropped", rd, gold(32'h208 >> 2));
      go(0, 0, 32'h2000, 0, rd, hit, rb, wb, b0);
      chk(!hit && rb == 4, "R12", "preloaded line gone", 32'(hit), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cold();
      t_write_hit();
      t_write_miss();
      t_ways();
      t_dirty();
      t_preload();
      t_uncached();
      t_disabled();
      t_inval();
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule